// File: doc/BRIEF.md
# Secure Fuse Initialization Sequencer

This block brings a processor subsystem out of reset under fuse control after power-up. As soon as its own reset is gone it asks the configuration controller for the fuse image. It collects the image one word at a time over a request/valid transfer into a shadow register. It then checks every security option field for a legal code. If every field is legal, it sends the clock-control field to the clock manager and the memory-control field to the reset manager. It then releases the system block resets one by one, then the peripherals (marked secure), and the processor core last.

The security-option fields (authentication mode, encryption mode, key source, key length) are published through a small read-only register window for boot code, next to a status word. A bad transfer, a transfer that stalls, or an illegal field puts the block in a locked state with every reset held. It does not retry. Only a pulse on the external reconfiguration input starts the sequence again.

Top module: `fuse_seq_top`

## Requirements
- R1: After reset, `cfg_req_o` is 1. Every reset output is 0 (held). Both fuse outputs and both readable registers are 0.
- R2: Fuse word k is captured into image bits [k*WORD_W +: WORD_W] on a cycle with `cfg_req_o` and `cfg_valid_i` both high. `cfg_req_o` goes low at the edge that accepts the last word.
- R3: Image bits [15:8] hold four 2-bit options: auth [9:8], enc [11:10], key source [13:12] and key length [15:14]. Code 2'b11 is illegal for auth, enc and key length. Key source accepts only 2'b00 and 2'b01. The error cause is the first failing field in the order auth (3), enc (4), key source (5), key length (6).
- R4: `cfg_err_i` high with `cfg_valid_i` locks the block with cause 1. TIMEOUT consecutive request cycles without `cfg_valid_i` lock it with cause 2. An accepted word restarts that count.
- R5: While locked, every reset output stays 0 and `cfg_req_o` is 0. `cfg_valid_i` has no effect, and the status word is unchanged.
- R6: A `reconfig_i` pulse, from any state, clears status, fuse outputs and readable registers at the next edge. It re-asserts every reset and raises `cfg_req_o`.
- R7: On success, `clk_fuse_o` = image[3:0] and `mem_fuse_o` = image[7:4]. Both appear at the first edge after the edge that accepts the last word, and both hold until restart. A failed check leaves them 0.
- R8: Reading address 0 returns image[15:8], zero-extended, once the check has passed, and 0 otherwise.
- R9: Reading address 1 returns the status word: bit 0 done, bit 1 error, bits [6:4] cause. Other addresses read 0.
- R10: Counting the edge that accepts the last word as edge 0, `sys_rst_n_o[i]` goes high at edge 2+i. `periph_rst_n_o` goes high at edge 2+NSYS, with `periph_secure_o` already high. `cpu_rst_n_o` and the done flag go high at edge 3+NSYS.
- R11: A released reset stays released until `reconfig_i` or `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer |
| reconfig_i | input | 1 | External reconfiguration pulse that restarts the sequence |
| cfg_req_o | output | 1 | Request for fuse words |
| cfg_valid_i | input | 1 | Fuse word valid |
| cfg_err_i | input | 1 | Transfer error flag qualified by valid |
| cfg_word_i | input | WORD_W | Fuse word |
| sys_rst_n_o | output | NSYS | Per-block system resets, active low |
| periph_rst_n_o | output | 1 | Peripheral reset, active low |
| periph_secure_o | output | 1 | Peripherals come up in secure state |
| cpu_rst_n_o | output | 1 | Processor core reset, active low |
| clk_fuse_o | output | 4 | Clock-control field to the clock manager |
| mem_fuse_o | output | 4 | Memory-control field to the reset manager |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Register read data |

## Verification
A corrupted state register or word index shows up within one edge. Either `cfg_req_o` stays high after the last word, or fuse fields land in the wrong slots and `clk_fuse_o` or the address 0 readback mismatches at the next edge. A release counter that skips or stalls breaks the one-reset-per-edge staircase. Every stage of that staircase is compared edge by edge. A faulty legality decode or priority shows as a wrong cause code on the edge after the transfer. A lock that leaks shows as a reset going high or a request reappearing while the error flag is still set.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

    localparam int CLK_LSB = 0;
    localparam int CLK_W   = 4;
    localparam int MEM_LSB = 4;
    localparam int MEM_W   = 4;
    localparam int SEC_LSB = 8;
    localparam int SEC_W   = 8;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_XFER = 3'd1,
        CAUSE_TMO  = 3'd2,
        CAUSE_AUTH = 3'd3,
        CAUSE_ENC  = 3'd4,
        CAUSE_KSRC = 3'd5,
        CAUSE_KLEN = 3'd6
    } cause_e;

    typedef enum logic [2:0] {
        ST_REQ   = 3'd0,
        ST_CHECK = 3'd1,
        ST_DIST  = 3'd2,
        ST_RUN   = 3'd3,
        ST_LOCK  = 3'd4
    } state_e;

    // packed MSB first: klen [7:6], ksrc [5:4], enc [3:2], auth [1:0]
    typedef struct packed {
        logic [1:0] klen;
        logic [1:0] ksrc;
        logic [1:0] enc;
        logic [1:0] auth;
    } sec_t;

    // three legal codes: everything except all-ones
    function automatic logic tri_code_ok(input logic [1:0] c);
        return c != 2'b11;
    endfunction

    // two legal codes: upper bit must be clear
    function automatic logic duo_code_ok(input logic [1:0] c);
        return c[1] == 1'b0;
    endfunction

endpackage

// File: rtl/fuse_check.sv
module fuse_check
    import fuse_seq_pkg::*;
(
    input  sec_t   sec_i,
    output logic   ok_o,
    output cause_e cause_o
);

    // fixed priority: auth, enc, key source, key length
    always_comb begin
        cause_o = CAUSE_NONE;
        if (!tri_code_ok(sec_i.auth)) begin
            cause_o = CAUSE_AUTH;
        end else if (!tri_code_ok(sec_i.enc)) begin
            cause_o = CAUSE_ENC;
        end else if (!duo_code_ok(sec_i.ksrc)) begin
            cause_o = CAUSE_KSRC;
        end else if (!tri_code_ok(sec_i.klen)) begin
            cause_o = CAUSE_KLEN;
        end
        ok_o = (cause_o == CAUSE_NONE);
    end

endmodule

// File: rtl/fuse_xfer.sv
module fuse_xfer #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 2,
    parameter int TIMEOUT = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      active_i,
    input  logic                      valid_i,
    input  logic                      err_i,
    input  logic [WORD_W-1:0]         word_i,
    output logic [WORD_W*N_WORDS-1:0] shadow_o,
    output logic                      done_o,
    output logic                      err_o,
    output logic                      tmo_o
);

    localparam int FUSE_W = WORD_W * N_WORDS;
    localparam int IDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int TMO_W  = $clog2(TIMEOUT + 1);

    typedef struct packed {
        logic [FUSE_W-1:0] shadow;
        logic [IDX_W-1:0]  idx;
        logic [TMO_W-1:0]  tcnt;
    } xfer_t;

    xfer_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        err_o  = 1'b0;
        tmo_o  = 1'b0;
        if (clear_i) begin
            d = '0;
        end else if (active_i) begin
            if (valid_i) begin
                d.tcnt = '0;
                if (err_i) begin
                    err_o = 1'b1;
                end else begin
                    d.shadow[int'(q.idx)*WORD_W +: WORD_W] = word_i;
                    if (q.idx == IDX_W'(N_WORDS - 1)) begin
                        done_o = 1'b1;
                        d.idx  = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end else if (q.tcnt == TMO_W'(TIMEOUT - 1)) begin
                tmo_o  = 1'b1;
                d.tcnt = '0;
            end else begin
                d.tcnt = q.tcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign shadow_o = q.shadow;

endmodule

// File: rtl/fuse_rel.sv
module fuse_rel #(
    parameter int NSYS = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            start_i,
    output logic [NSYS-1:0] sys_rel_o,
    output logic            per_rel_o,
    output logic            cpu_rel_o
);

    localparam int LAST  = NSYS + 2;
    localparam int STG_W = $clog2(LAST + 1);

    logic [STG_W-1:0] stage_q, stage_d;

    always_comb begin
        stage_d = stage_q;
        if (clear_i) begin
            stage_d = '0;
        end else if (start_i && stage_q == '0) begin
            stage_d = STG_W'(1);
        end else if (stage_q != '0 && stage_q < STG_W'(LAST)) begin
            stage_d = stage_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    for (genvar g = 0; g < NSYS; g++) begin : g_sys
        assign sys_rel_o[g] = (stage_q > STG_W'(g));
    end

    assign per_rel_o = (stage_q > STG_W'(NSYS));
    assign cpu_rel_o = (stage_q > STG_W'(NSYS + 1));

endmodule

// File: rtl/fuse_seq_top.sv
module fuse_seq_top
    import fuse_seq_pkg::*;
#(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 2,
    parameter int TIMEOUT = 64,
    parameter int NSYS    = 3,
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reconfig_i,
    output logic              cfg_req_o,
    input  logic              cfg_valid_i,
    input  logic              cfg_err_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    output logic [NSYS-1:0]   sys_rst_n_o,
    output logic              periph_rst_n_o,
    output logic              periph_secure_o,
    output logic              cpu_rst_n_o,
    output logic [CLK_W-1:0]  clk_fuse_o,
    output logic [MEM_W-1:0]  mem_fuse_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int FUSE_W = WORD_W * N_WORDS;

    typedef struct packed {
        state_e           st;
        logic             err;
        cause_e           cause;
        logic             secure;
        logic [CLK_W-1:0] clkf;
        logic [MEM_W-1:0] memf;
        sec_t             sec;
    } seq_t;

    seq_t q, d;

    logic [FUSE_W-1:0] shadow;
    logic              xfer_done, xfer_err, xfer_tmo;
    logic              chk_ok;
    cause_e            chk_cause;
    logic              rel_start;
    logic [NSYS-1:0]   sys_rel;
    logic              per_rel, cpu_rel;
    logic              lock_flag;
    logic              unused_hi;
    logic [DATA_W-1:0] status;

    fuse_xfer #(
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .TIMEOUT(TIMEOUT)
    ) xfer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (reconfig_i),
        .active_i(q.st == ST_REQ),
        .valid_i (cfg_valid_i),
        .err_i   (cfg_err_i),
        .word_i  (cfg_word_i),
        .shadow_o(shadow),
        .done_o  (xfer_done),
        .err_o   (xfer_err),
        .tmo_o   (xfer_tmo)
    );

    fuse_check check_i (
        .sec_i  (sec_t'(shadow[SEC_LSB +: SEC_W])),
        .ok_o   (chk_ok),
        .cause_o(chk_cause)
    );

    fuse_rel #(
        .NSYS(NSYS)
    ) rel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (reconfig_i),
        .start_i  (rel_start),
        .sys_rel_o(sys_rel),
        .per_rel_o(per_rel),
        .cpu_rel_o(cpu_rel)
    );

    always_comb begin
        d         = q;
        rel_start = 1'b0;
        if (reconfig_i) begin
            d    = '0;
            d.st = ST_REQ;
        end else begin
            unique case (q.st)
                ST_REQ: begin
                    if (xfer_err) begin
                        d.st    = ST_LOCK;
                        d.err   = 1'b1;
                        d.cause = CAUSE_XFER;
                    end else if (xfer_tmo) begin
                        d.st    = ST_LOCK;
                        d.err   = 1'b1;
                        d.cause = CAUSE_TMO;
                    end else if (xfer_done) begin
                        d.st = ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!chk_ok) begin
                        d.st    = ST_LOCK;
                        d.err   = 1'b1;
                        d.cause = chk_cause;
                    end else begin
                        d.st     = ST_DIST;
                        d.secure = 1'b1;
                        d.clkf   = shadow[CLK_LSB +: CLK_W];
                        d.memf   = shadow[MEM_LSB +: MEM_W];
                        d.sec    = sec_t'(shadow[SEC_LSB +: SEC_W]);
                    end
                end
                ST_DIST: begin
                    rel_start = 1'b1;
                    d.st      = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign unused_hi       = ^shadow[FUSE_W-1:SEC_LSB+SEC_W];
    assign lock_flag       = q.err;
    assign cfg_req_o       = (q.st == ST_REQ);
    assign sys_rst_n_o     = sys_rel;
    assign periph_rst_n_o  = per_rel;
    assign periph_secure_o = q.secure;
    assign cpu_rst_n_o     = cpu_rel;
    assign clk_fuse_o      = q.clkf;
    assign mem_fuse_o      = q.memf;
    assign status          = DATA_W'({q.cause, 2'b00, q.err, cpu_rel});

    always_comb begin
        case (rd_addr_i)
            ADDR_W'(0): rd_data_o = DATA_W'(q.sec);
            ADDR_W'(1): rd_data_o = status;
            default:    rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/fuse_seq_chk.sv
module fuse_seq_chk #(
    parameter int NSYS = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reconfig_i,
    input logic            cfg_req_o,
    input logic [NSYS-1:0] sys_rst_n_o,
    input logic            periph_rst_n_o,
    input logic            periph_secure_o,
    input logic            cpu_rst_n_o,
    input logic [3:0]      clk_fuse_o,
    input logic [3:0]      mem_fuse_o,
    input logic            lock_flag
);

    assert_cpu_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n_o |-> (periph_rst_n_o && (&sys_rst_n_o)));

    assert_periph_secure_R10: assert property (@(posedge clk) disable iff (!rst_n)
        periph_rst_n_o |-> periph_secure_o);

    for (genvar g = 1; g < NSYS; g++) begin : g_order
        assert_sys_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
            sys_rst_n_o[g] |-> sys_rst_n_o[g-1]);
    end

    assert_lock_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag |-> (!cfg_req_o && !(|sys_rst_n_o) && !periph_rst_n_o && !cpu_rst_n_o));

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && !reconfig_i) |=> lock_flag);

    assert_fuse_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n_o[0] && !reconfig_i) |=> ($stable(clk_fuse_o) && $stable(mem_fuse_o)));

    assert_cpu_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rst_n_o && !reconfig_i) |=> cpu_rst_n_o);

endmodule

bind fuse_seq_top fuse_seq_chk #(
    .NSYS(NSYS)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reconfig_i     (reconfig_i),
    .cfg_req_o      (cfg_req_o),
    .sys_rst_n_o    (sys_rst_n_o),
    .periph_rst_n_o (periph_rst_n_o),
    .periph_secure_o(periph_secure_o),
    .cpu_rst_n_o    (cpu_rst_n_o),
    .clk_fuse_o     (clk_fuse_o),
    .mem_fuse_o     (mem_fuse_o),
    .lock_flag      (lock_flag)
);

// File: tb/fuse_seq_top_tb_top.sv
module fuse_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int N_WORDS    = 2;
    localparam int TMO        = 16;
    localparam int NSYS       = 3;
    localparam int NVEC       = 8;

    // {image[31:0], expected cause[2:0]}
    localparam logic [34:0] VEC [NVEC] = '{
        {32'hABCD_5A93, 3'd0},
        {32'h0000_0312, 3'd3},
        {32'h0000_0C00, 3'd4},
        {32'h0000_2000, 3'd5},
        {32'h0000_C0FF, 3'd6},
        {32'h0000_FF00, 3'd3},
        {32'h0000_F000, 3'd5},
        {32'hFFFF_96E7, 3'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reconfig = 1'b0;
    logic              cfg_req;
    logic              cfg_valid = 1'b0;
    logic              cfg_err = 1'b0;
    logic [WORD_W-1:0] cfg_word = '0;
    logic [NSYS-1:0]   sys_rst_n;
    logic              per_rst_n, per_sec, cpu_rst_n;
    logic [3:0]        clk_fuse, mem_fuse;
    logic [1:0]        rd_addr = '0;
    logic [31:0]       rd_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_seq_top #(
        .WORD_W (WORD_W),
        .N_WORDS(N_WORDS),
        .TIMEOUT(TMO),
        .NSYS   (NSYS),
        .ADDR_W (2),
        .DATA_W (32)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .reconfig_i     (reconfig),
        .cfg_req_o      (cfg_req),
        .cfg_valid_i    (cfg_valid),
        .cfg_err_i      (cfg_err),
        .cfg_word_i     (cfg_word),
        .sys_rst_n_o    (sys_rst_n),
        .periph_rst_n_o (per_rst_n),
        .periph_secure_o(per_sec),
        .cpu_rst_n_o    (cpu_rst_n),
        .clk_fuse_o     (clk_fuse),
        .mem_fuse_o     (mem_fuse),
        .rd_addr_i      (rd_addr),
        .rd_data_o      (rd_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic send(input logic [31:0] img);
        for (int w = 0; w < N_WORDS; w++) begin
            cfg_valid = 1'b1;
            cfg_word  = img[w*WORD_W +: WORD_W];
            tick();
        end
        cfg_valid = 1'b0;
    endtask

    task automatic restart();
        reconfig = 1'b1;
        tick();
        reconfig = 1'b0;
    endtask

    function automatic logic [31:0] rels();
        return 32'({cpu_rst_n, per_rst_n, sys_rst_n});
    endfunction

    function automatic logic [31:0] status_word(input logic [2:0] c, input logic e, input logic dn);
        return 32'({c, 2'b00, e, dn});
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 request after reset", 32'(cfg_req), 32'd1);
        chk("R1 resets held", rels(), 32'd0);
        chk("R1 fuse outputs zero", 32'({clk_fuse, mem_fuse}), 32'd0);
        rd(2'd0, v); chk("R1 boot register zero", v, 32'd0);
        rd(2'd1, v); chk("R1 status zero", v, 32'd0);

        // R4 timeout from reset
        repeat (TMO - 1) tick();
        chk("R4 no timeout one cycle early", 32'(cfg_req), 32'd1);
        tick();
        rd(2'd1, v); chk("R4 timeout cause", v, status_word(3'd2, 1'b1, 1'b0));

        // R5 lock ignores transfers
        send(32'h0000_5A93);
        tick();
        rd(2'd1, v); chk("R5 status unchanged in lock", v, status_word(3'd2, 1'b1, 1'b0));
        chk("R5 resets held in lock", rels(), 32'd0);
        chk("R5 no request in lock", 32'(cfg_req), 32'd0);
        chk("R5 fuse outputs untouched", 32'({clk_fuse, mem_fuse}), 32'd0);

        // R6 restart clears the lock
        restart();
        rd(2'd1, v); chk("R6 status cleared", v, 32'd0);
        chk("R6 request raised", 32'(cfg_req), 32'd1);

        // R4 transfer error on the second word
        cfg_valid = 1'b1; cfg_word = 16'h1234; tick();
        cfg_err = 1'b1; tick();
        cfg_valid = 1'b0; cfg_err = 1'b0;
        rd(2'd1, v); chk("R4 transfer error cause", v, status_word(3'd1, 1'b1, 1'b0));
        chk("R4 resets held on transfer error", rels(), 32'd0);

        // R4 accepted word restarts the timeout count
        restart();
        repeat (TMO - 2) tick();
        cfg_valid = 1'b1; cfg_word = 16'h0000; tick(); cfg_valid = 1'b0;
        repeat (TMO - 1) tick();
        chk("R4 count restarted by word", 32'(cfg_req), 32'd1);
        tick();
        rd(2'd1, v); chk("R4 timeout after restart", v, status_word(3'd2, 1'b1, 1'b0));

        // vector table: R2 R3 R7 R8 R9 R10
        for (int k = 0; k < NVEC; k++) begin
            logic [31:0] img;
            logic [2:0]  ec;
            img = VEC[k][34:3];
            ec  = VEC[k][2:0];
            restart();
            chk("R6 request after restart", 32'(cfg_req), 32'd1);
            send(img);
            chk("R2 request drops after last word", 32'(cfg_req), 32'd0);
            tick();
            if (ec == 3'd0) begin
                chk("R7 clock field", 32'(clk_fuse), 32'(img[3:0]));
                chk("R7 memory field", 32'(mem_fuse), 32'(img[7:4]));
                rd(2'd0, v); chk("R8 boot register", v, 32'(img[15:8]));
                chk("R10 nothing released at distribution", rels(), 32'd0);
                for (int s = 1; s <= NSYS + 2; s++) begin
                    logic [31:0] exp;
                    tick();
                    exp = '0;
                    for (int i = 0; i < NSYS; i++) exp[i] = (s > i);
                    exp[NSYS]     = (s > NSYS);
                    exp[NSYS + 1] = (s > NSYS + 1);
                    chk("R10 release staircase", rels(), exp);
                end
                chk("R10 peripherals secure", 32'(per_sec), 32'd1);
                rd(2'd1, v); chk("R9 done status", v, status_word(3'd0, 1'b0, 1'b1));
            end else begin
                rd(2'd1, v); chk("R3 illegal field cause", v, status_word(ec, 1'b1, 1'b0));
                chk("R3 resets held on illegal field", rels(), 32'd0);
                chk("R7 no fuse output on failure", 32'({clk_fuse, mem_fuse}), 32'd0);
                rd(2'd0, v); chk("R8 boot register zero on failure", v, 32'd0);
            end
        end

        // R11 releases persist, R9 unused addresses
        repeat (10) tick();
        chk("R11 releases kept", rels(), 32'((1 << (NSYS + 2)) - 1));
        rd(2'd2, v); chk("R9 address 2 reads zero", v, 32'd0);
        rd(2'd3, v); chk("R9 address 3 reads zero", v, 32'd0);

        // R6 restart after success re-asserts everything
        restart();
        chk("R6 resets re-asserted", rels(), 32'd0);
        chk("R6 fuse outputs cleared", 32'({clk_fuse, mem_fuse}), 32'd0);
        rd(2'd0, v); chk("R6 boot register cleared", v, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule